// File: doc/BRIEF.md
# Local Walsh Codeword Decoder

This block recovers the six-bit index of a 64-chip Walsh codeword while looking at only part of the received chips. It treats the codeword as the Kronecker product of two length-8 Walsh codes. Each chip index n is split as n = 8*row + col, and each codeword index j is split as j = 8*jh + jl. Several small 8-point Hadamard transforms run in parallel. Some of them take one row of eight chips, and their outputs point to jl. The others take one column of eight chips, and their outputs point to jh. The absolute correlations of each group are added point by point. The largest entry in each group gives three of the six output bits.

A caller pulses `start` with the first chip and streams the remaining 63 chips on the following cycles. The `num_fhts` input selects how many transforms take part, which trades decoding quality against switching activity. Transforms above that count are held cleared, so they do not toggle. A new codeword may begin while the previous one is still being transformed, which gives a throughput of one codeword every 64 cycles.

Top module: `lwd_decoder`

## Requirements
- R1: A cycle with `start` high writes `sym_in` as chip 0, and the next 63 cycles supply chips 1 to 63 in order. A `start` during a capture abandons the partial codeword and restarts at chip 0, and the abandoned codeword produces no result.
- R2: Transform i (0 to 7) takes part only when i is below the active count. When i is even it takes the chips 8*(i/2)+m. When i is odd it takes the chips 8*m+(i/2). In both cases m = 0..7 is its input position.
- R3: `num_fhts` is sampled in the `start` cycle. Values below 2 act as 2 and values above 8 act as 8.
- R4: Each transform computes, for k = 0..7, the sum over m of input m multiplied by (-1)^popcount(k AND m), with `sym_in` read as two's complement. The magnitudes from the even-numbered transforms are summed per k, and the index of the largest sum is `bits_out[2:0]`. The magnitudes from the odd-numbered transforms are summed the same way, and the index of their largest sum is `bits_out[5:3]`.
- R5: `ready` and the new `bits_out` appear 67 cycles after the `start` cycle.
- R6: `ready` is high for exactly one cycle per codeword. `bits_out` changes only together with `ready` and otherwise holds its value. Reset clears both outputs to 0.
- R7: When two or more sums tie for the largest value, the lowest index wins.
- R8: A new `start` in the cycle right after chip 63 does not disturb the codeword that is still being transformed.
- R9: Chips that no active transform reads have no effect on `bits_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Marks chip 0 of a codeword |
| sym_in | input | 10 | Received chip, two's complement |
| num_fhts | input | 4 | Requested number of active transforms |
| bits_out | output | 6 | Decoded index {high 3, low 3} |
| ready | output | 1 | One-cycle pulse when `bits_out` is new |

## Verification
The bench fills rows and columns that active transforms read with one codeword, and fills all other chips with a stronger, different codeword. A decoder that ignores the active count or mixes up rows and columns then reports the wrong codeword, and out-of-range counts show up the same way when they are not clamped. Inputs made of all zeros and sums of two codewords force equal maxima, so a search that prefers the later index gives different bits. Back-to-back codewords and a restart in the middle of a capture expose a pipeline that lets a new capture corrupt the codeword in flight, or one that emits a result for the abandoned codeword. The arrival cycle of every result is also checked against the fixed 67-cycle latency.

// File: rtl/lwd_pkg.sv
package lwd_pkg;
  localparam int unsigned CW_LEN = 64;
  localparam int unsigned CW_AW  = $clog2(CW_LEN);
  localparam int unsigned SLICE  = 8;
  localparam int unsigned IDX_W  = $clog2(SLICE);
endpackage

// File: rtl/lwd_symbol_buffer.sv
module lwd_symbol_buffer #(
  parameter int unsigned SYM_W = 10,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        we,
  input  logic [AW-1:0]               waddr,
  input  logic [SYM_W-1:0]            wdata,
  output logic [DEPTH-1:0][SYM_W-1:0] mem_q
);
  logic [DEPTH-1:0][SYM_W-1:0] mem;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign mem_q = mem;
endmodule

// File: rtl/lwd_fht8.sv
module lwd_fht8 #(
  parameter int unsigned IN_W  = 10,
  parameter int unsigned PTS   = 8,
  localparam int unsigned STG  = $clog2(PTS),
  localparam int unsigned OUT_W = IN_W + STG
) (
  input  logic                      clk,
  input  logic                      clr,
  input  logic                      en,
  input  logic [PTS-1:0][IN_W-1:0]  x,
  output logic [PTS-1:0][OUT_W-1:0] y
);
  logic signed [OUT_W-1:0] st [STG+1][PTS];

  // butterflies with spans 1, 2, 4 give natural Hadamard order
  always_comb begin
    for (int m = 0; m < PTS; m++) st[0][m] = OUT_W'($signed(x[m]));
    for (int s = 0; s < STG; s++) begin
      for (int m = 0; m < PTS; m++) begin
        if (((m >> s) & 1) == 0) st[s+1][m] = st[s][m] + st[s][m ^ (1 << s)];
        else                     st[s+1][m] = st[s][m ^ (1 << s)] - st[s][m];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      y <= '0;
    end else if (en) begin
      for (int m = 0; m < PTS; m++) y[m] <= st[STG][m];
    end
  end
endmodule

// File: rtl/lwd_argmax8.sv
module lwd_argmax8 #(
  parameter int unsigned VAL_W = 15,
  parameter int unsigned PTS   = 8,
  localparam int unsigned IW   = $clog2(PTS)
) (
  input  logic [PTS-1:0][VAL_W-1:0] val,
  output logic [IW-1:0]             idx
);
  logic [VAL_W-1:0] best;

  // strict compare keeps the earliest index on ties
  always_comb begin
    best = val[0];
    idx  = '0;
    for (int k = 1; k < PTS; k++) begin
      if (val[k] > best) begin
        best = val[k];
        idx  = IW'(k);
      end
    end
  end
endmodule

// File: rtl/lwd_decoder.sv
module lwd_decoder
  import lwd_pkg::*;
#(
  parameter int unsigned SYM_W = 10,
  parameter int unsigned N_FHT = 8,
  localparam int unsigned CNT_W = $clog2(N_FHT + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [SYM_W-1:0]   sym_in,
  input  logic [CNT_W-1:0]   num_fhts,
  output logic [2*IDX_W-1:0] bits_out,
  output logic               ready
);
  localparam int unsigned CORR_W = SYM_W + IDX_W;
  localparam int unsigned SUM_W  = CORR_W + $clog2(N_FHT / 2);
  localparam int unsigned N_MIN  = 2;

  logic [CW_LEN-1:0][SYM_W-1:0]          buf_q;
  logic                                  cap_on, cap_done, fht_vld, sum_vld;
  logic [CW_AW-1:0]                      cap_idx;
  logic [CNT_W-1:0]                      n_req, n_cap, n_act;
  logic [N_FHT-1:0][SLICE-1:0][CORR_W-1:0] corr, mag;
  logic [SLICE-1:0][SUM_W-1:0]           lo_sum, hi_sum, lo_q, hi_q;
  logic [IDX_W-1:0]                      lo_idx, hi_idx;

  assign n_req = (num_fhts < CNT_W'(N_MIN)) ? CNT_W'(N_MIN) :
                 (num_fhts > CNT_W'(N_FHT)) ? CNT_W'(N_FHT) : num_fhts;

  lwd_symbol_buffer #(.SYM_W(SYM_W), .DEPTH(CW_LEN)) u_buf (
    .clk   (clk),
    .we    (start | cap_on),
    .waddr (start ? '0 : cap_idx),
    .wdata (sym_in),
    .mem_q (buf_q)
  );

  // capture sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_on   <= 1'b0;
      cap_idx  <= '0;
      cap_done <= 1'b0;
      n_cap    <= CNT_W'(N_MIN);
      n_act    <= CNT_W'(N_MIN);
    end else begin
      cap_done <= 1'b0;
      if (start) begin
        cap_on  <= 1'b1;
        cap_idx <= CW_AW'(1);
        n_cap   <= n_req;
      end else if (cap_on) begin
        cap_idx <= cap_idx + 1'b1;
        if (cap_idx == CW_AW'(CW_LEN - 1)) begin
          cap_on   <= 1'b0;
          cap_done <= 1'b1;
          n_act    <= n_cap;
        end
      end
    end
  end

  // transform bank: even instances read rows, odd instances read columns
  for (genvar i = 0; i < N_FHT; i++) begin : g_fht
    localparam int unsigned FIX = i / 2;
    logic [SLICE-1:0][SYM_W-1:0] x_sel;
    for (genvar m = 0; m < SLICE; m++) begin : g_sel
      if (i % 2 == 0) begin : g_row
        assign x_sel[m] = buf_q[SLICE*FIX + m];
      end else begin : g_col
        assign x_sel[m] = buf_q[SLICE*m + FIX];
      end
      assign mag[i][m] = corr[i][m][CORR_W-1] ? (~corr[i][m] + 1'b1) : corr[i][m];
    end
    lwd_fht8 #(.IN_W(SYM_W), .PTS(SLICE)) u_fht (
      .clk (clk),
      .clr (rst | (n_act <= CNT_W'(i))),
      .en  (cap_done),
      .x   (x_sel),
      .y   (corr[i])
    );
  end

  always_comb begin
    lo_sum = '0;
    hi_sum = '0;
    for (int i = 0; i < N_FHT; i++) begin
      for (int k = 0; k < SLICE; k++) begin
        if (i % 2 == 0) lo_sum[k] = lo_sum[k] + SUM_W'(mag[i][k]);
        else            hi_sum[k] = hi_sum[k] + SUM_W'(mag[i][k]);
      end
    end
  end

  lwd_argmax8 #(.VAL_W(SUM_W), .PTS(SLICE)) u_max_lo (.val(lo_q), .idx(lo_idx));
  lwd_argmax8 #(.VAL_W(SUM_W), .PTS(SLICE)) u_max_hi (.val(hi_q), .idx(hi_idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      fht_vld  <= 1'b0;
      sum_vld  <= 1'b0;
      ready    <= 1'b0;
      bits_out <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
    end else begin
      fht_vld <= cap_done;
      sum_vld <= fht_vld;
      ready   <= sum_vld;
      if (fht_vld) begin
        lo_q <= lo_sum;
        hi_q <= hi_sum;
      end
      if (sum_vld) bits_out <= {hi_idx, lo_idx};
    end
  end
endmodule

// File: rtl/lwd_decoder_chk.sv
module lwd_decoder_chk #(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned OUT_W = 6,
  parameter int unsigned N_MAX = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             ready,
  input logic [OUT_W-1:0] bits_out,
  input logic             cap_done,
  input logic [CNT_W-1:0] n_act
);
  a_r5_done_to_ready: assert property (@(posedge clk) disable iff (rst)
    cap_done |-> ##3 ready);

  a_r5_ready_has_cause: assert property (@(posedge clk) disable iff (rst)
    ready |-> $past(cap_done, 3));

  a_r6_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready);

  a_r6_bits_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(bits_out) |-> ready);

  a_r3_count_clamped: assert property (@(posedge clk) disable iff (rst)
    (n_act >= CNT_W'(2)) && (n_act <= CNT_W'(N_MAX)));
endmodule

bind lwd_decoder lwd_decoder_chk i_chk (
  .clk      (clk),
  .rst      (rst),
  .ready    (ready),
  .bits_out (bits_out),
  .cap_done (cap_done),
  .n_act    (n_act)
);

// File: tb/test_lwd_decoder.sv
module test_lwd_decoder;
  logic       clk = 1'b0;
  logic       rst, start;
  logic [9:0] sym_in;
  logic [3:0] num_fhts;
  logic [5:0] bits_out;
  logic       ready;

  always #10 clk = ~clk;

  lwd_decoder i_lwd_decoder (
    .clk(clk), .rst(rst), .start(start), .sym_in(sym_in),
    .num_fhts(num_fhts), .bits_out(bits_out), .ready(ready)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  bit done = 1'b0, mon_on = 1'b0, prev_ready = 1'b0;
  logic [5:0] last_bits = '0;
  logic signed [9:0] sv [64];
  logic [15:0] lfsr = 16'hACE1;
  logic [5:0] q_bits [$];
  int         q_due  [$];
  string      q_tag  [$];

  function automatic int wsign(int j, int n);
    return (^(j[5:0] & n[5:0])) ? -1 : 1;
  endfunction

  function automatic logic [5:0] model(int n);
    int nc, corr, x, bv;
    int acc [2][8];
    logic [2:0] best [2];
    nc = (n < 2) ? 2 : ((n > 8) ? 8 : n);
    for (int g = 0; g < 2; g++) for (int k = 0; k < 8; k++) acc[g][k] = 0;
    for (int i = 0; i < nc; i++) begin
      for (int k = 0; k < 8; k++) begin
        corr = 0;
        for (int m = 0; m < 8; m++) begin
          x = (i % 2 == 0) ? int'(sv[8*(i/2) + m]) : int'(sv[8*m + i/2]);
          corr += (^(k[2:0] & m[2:0])) ? -x : x;
        end
        acc[i%2][k] += (corr < 0) ? -corr : corr;
      end
    end
    for (int g = 0; g < 2; g++) begin
      best[g] = 3'd0;
      bv = acc[g][0];
      for (int k = 1; k < 8; k++) if (acc[g][k] > bv) begin bv = acc[g][k]; best[g] = k[2:0]; end
    end
    return {best[1], best[0]};
  endfunction

  task automatic fill_clean(int j, int amp, bit noisy);
    int nz;
    for (int n = 0; n < 64; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      nz = noisy ? (int'(lfsr[6:0]) - 64) : 0;
      sv[n] = 10'(amp * wsign(j, n) + nz);
    end
  endtask

  // codeword a on row 0 and column 0, stronger codeword b elsewhere
  task automatic fill_mix(int a, int b);
    for (int n = 0; n < 64; n++)
      sv[n] = ((n < 8) || (n % 8 == 0)) ? 10'(100 * wsign(a, n)) : 10'(200 * wsign(b, n));
  endtask

  task automatic idle(int c);
    start = 1'b0;
    repeat (c) @(negedge clk);
  endtask

  task automatic send(int n, string tag);
    @(negedge clk);
    q_bits.push_back(model(n));
    q_due.push_back(cyc + 67);
    q_tag.push_back(tag);
    for (int k = 0; k < 64; k++) begin
      if (k > 0) @(negedge clk);
      start    = (k == 0);
      sym_in   = sv[k];
      num_fhts = n[3:0];
    end
  endtask

  task automatic partial(int cnt);
    for (int k = 0; k < cnt; k++) begin
      @(negedge clk);
      start  = (k == 0);
      sym_in = 10'(k * 37 - 300);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (ready) begin
        checks++;
        if (prev_ready) begin fails++; $display("FAIL R6 ready width: actual 2+ cycles expected 1"); end
        if (q_bits.size() == 0) begin
          checks++; fails++;
          $display("FAIL R5 unexpected ready: actual bits=%0d expected none", bits_out);
        end else begin
          checks++;
          if (bits_out !== q_bits[0]) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", q_tag[0], bits_out, q_bits[0]);
          end
          checks++;
          if (cyc != q_due[0]) begin
            fails++;
            $display("FAIL R5 latency: actual cycle %0d expected %0d", cyc, q_due[0]);
          end
          void'(q_bits.pop_front()); void'(q_due.pop_front()); void'(q_tag.pop_front());
        end
        last_bits = bits_out;
      end else begin
        checks++;
        if (bits_out !== last_bits) begin
          fails++;
          $display("FAIL R6 hold: actual %0d expected %0d", bits_out, last_bits);
        end
      end
      prev_ready = ready;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; start = 1'b0; sym_in = '0; num_fhts = 4'd8;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (ready !== 1'b0 || bits_out !== 6'd0) begin
      fails++;
      $display("FAIL R6 reset: actual ready=%0b bits=%0d expected 0/0", ready, bits_out);
    end
    mon_on = 1'b1;

    fill_clean(0, 60, 0);  send(8, "R4 clean j=0");  idle(5);
    fill_clean(45, 60, 0); send(8, "R4 clean j=45"); idle(5);
    fill_clean(63, 60, 0); send(8, "R4 clean j=63"); idle(5);
    fill_clean(18, 60, 0); send(8, "R4 clean j=18"); idle(5);
    fill_clean(37, 60, 1); send(5, "R2 noisy n=5");  idle(3);
    fill_clean(12, 60, 1); send(3, "R2 noisy n=3");  idle(3);
    fill_clean(50, 60, 1); send(2, "R2 noisy n=2");  idle(3);

    fill_mix(21, 42); send(2,  "R9 unread chips n=2"); idle(3);
    fill_mix(21, 42); send(8,  "R2 all slices n=8");   idle(3);
    fill_mix(13, 54); send(0,  "R3 clamp low n=0");    idle(3);
    fill_mix(13, 54); send(1,  "R3 clamp low n=1");    idle(3);
    fill_mix(13, 54); send(15, "R3 clamp high n=15");  idle(3);

    for (int n = 0; n < 64; n++) sv[n] = '0;
    send(8, "R7 tie all zero"); idle(3);
    for (int n = 0; n < 64; n++) sv[n] = 10'(50 * (wsign(5, n) + wsign(3, n)));
    send(8, "R7 tie j=5 and j=3"); idle(3);

    partial(20);
    fill_clean(27, 60, 0); send(8, "R1 restart"); idle(3);

    fill_clean(9, 60, 1);  send(8, "R8 back-to-back a");
    fill_clean(54, 60, 1); send(4, "R8 back-to-back b");
    fill_clean(33, 60, 1); send(6, "R8 back-to-back c");
    idle(2);

    while (q_bits.size() != 0) @(negedge clk);
    idle(10);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule